// File: doc/BRIEF.md
# Mesh Destination Address Translator

This block turns the virtual word address that a message is sent to into the X, Y and Z coordinates of a node in a three-dimensional mesh. It holds a small, fully associative set of mapping entries. Each entry covers one page-group, which is an aligned run of pages whose count is a power of two. It spreads those pages over a box-shaped region of nodes, and each side of that box is a power of two long. A per-entry spacing value chooses the interleaving. With a spacing of one page per node, consecutive pages go to consecutive nodes (cyclic). Larger spacings keep blocks of pages on one node before moving on.

System software loads entries through a write port, and the entries are replaced in round-robin order. The lookup port takes one address per cycle. Two cycles later it returns a valid strobe with either a hit and the node coordinates, or a miss. The first cycle compares the address against every entry and picks one. The second cycle computes the node offset from the chosen entry and adds it to the region's origin corner.

Top module: `dest_xlate`

## Requirements
- R1: After reset every entry is empty. Any lookup then returns a miss, and `rs_valid`, `rs_hit` and `rs_miss` are low while no result is due.
- R2: A lookup presented with `lk_valid` high at a clock edge produces `rs_valid` high after exactly two rising edges. Back-to-back lookups give one result per cycle, in order.
- R3: Bits [51:10] of `lk_vaddr` form the page number, and a page holds 1024 words. An entry matches when its page-number bits at and above position `len` equal the same bits of its tag. This means the page lies inside the aligned group of 2^`len` pages.
- R4: When no entry matches, the result has `rs_hit` low, `rs_miss` high, and all three coordinates zero.
- R5: The page offset inside the group is shifted right by `ppn`, where 2^`ppn` pages go to each node. The result is then reduced modulo 2^(ext_x+ext_y+ext_z). Its low ext_x bits are the X offset, the next ext_y bits are the Y offset, and the next ext_z bits are the Z offset.
- R6: The 16-bit start field holds X in bits [4:0], Y in bits [9:5] and Z in bits [15:10]. Each output coordinate is its start field plus its offset, truncated to that field's width, with no carry into the neighbouring field.
- R7: Writes fill slots 0, 1, ... 7 in turn and then wrap. The ninth write replaces slot 0.
- R8: When several entries match, the entry in the lowest-numbered slot supplies the result.
- R9: A lookup in the same cycle as a write sees the table as it was before that write. A lookup one cycle later sees the new entry.
- R10: With `lk_valid` low, no result appears: `rs_valid`, `rs_hit` and `rs_miss` stay low two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load one entry into the next round-robin slot |
| wr_tag | input | 42 | Page number of the group base |
| wr_start | input | 16 | Region origin corner {Z[5:0], Y[4:0], X[4:0]} |
| wr_len | input | 6 | log2 of the pages in the group |
| wr_ppn | input | 6 | log2 of the pages placed on each node |
| wr_ext_x | input | 3 | log2 of the region's X size |
| wr_ext_y | input | 3 | log2 of the region's Y size |
| wr_ext_z | input | 3 | log2 of the region's Z size |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | 52 | Destination virtual word address |
| rs_valid | output | 1 | Result strobe |
| rs_hit | output | 1 | Result came from a matching entry |
| rs_miss | output | 1 | No entry matched |
| rs_x | output | 5 | Node X coordinate |
| rs_y | output | 5 | Node Y coordinate |
| rs_z | output | 6 | Node Z coordinate |

## Verification
A table load and a lookup can fall in the same cycle. The bench provokes this by raising `wr_en` for a new entry together with `lk_valid` for an address that only that entry covers, then repeating the lookup in the next cycle. It judges the result by requiring a miss for the first lookup and a hit with the entry's coordinates for the second. A second collision comes from two entries covering the same pages. Once slot 0 is overwritten by the round-robin pointer, the same address must switch to the coordinates of the other entry.

// File: rtl/dxl_pkg.sv
package dxl_pkg;
    localparam int PAGE_W  = 10;
    localparam int TAG_W   = 42;
    localparam int VA_W    = TAG_W + PAGE_W;
    localparam int SX_W    = 5;
    localparam int SY_W    = 5;
    localparam int SZ_W    = 6;
    localparam int START_W = SX_W + SY_W + SZ_W;
    localparam int LOG_W   = 6;
    localparam int EXT_W   = 3;
    localparam int RB_W    = EXT_W + 2;

    typedef struct packed {
        logic [TAG_W-1:0]   tag;
        logic [START_W-1:0] start;
        logic [LOG_W-1:0]   len;
        logic [LOG_W-1:0]   ppn;
        logic [EXT_W-1:0]   ex;
        logic [EXT_W-1:0]   ey;
        logic [EXT_W-1:0]   ez;
    } dxl_entry_t;

    typedef struct packed {
        logic             valid;
        logic             hit;
        dxl_entry_t       ent;
        logic [TAG_W-1:0] off;
    } dxl_s1_t;
endpackage

// File: rtl/dxl_entry_store.sv
module dxl_entry_store
    import dxl_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  dxl_entry_t               wr_entry,
    output dxl_entry_t [ENTRIES-1:0] tbl,
    output logic [ENTRIES-1:0]       vld
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]       vld;
        logic [PTR_W-1:0]         ptr;
        dxl_entry_t [ENTRIES-1:0] tbl;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.tbl[st_q.ptr] = wr_entry;
            st_d.vld[st_q.ptr] = 1'b1;
            st_d.ptr           = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tbl = st_q.tbl;
    assign vld = st_q.vld;

    AST_WR_SLOT_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (vld[$past(st_q.ptr)] && tbl[$past(st_q.ptr)] == $past(wr_entry)))
        else $error("written entry not in its slot"); // R7
endmodule

// File: rtl/dxl_match.sv
module dxl_match
    import dxl_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_valid,
    input  logic [TAG_W-1:0]         vpn,
    input  dxl_entry_t [ENTRIES-1:0] tbl,
    input  logic [ENTRIES-1:0]       vld,
    output dxl_s1_t                  s1
);
    logic [ENTRIES-1:0] hit_vec;
    logic [TAG_W-1:0]   grp_mask [ENTRIES];

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
        assign grp_mask[gi] = {TAG_W{1'b1}} << tbl[gi].len;
        assign hit_vec[gi]  = vld[gi] && (((vpn ^ tbl[gi].tag) & grp_mask[gi]) == '0);
    end

    dxl_s1_t          s1_d, s1_q;
    dxl_entry_t       sel_ent;
    logic [TAG_W-1:0] sel_mask;

    always_comb begin
        sel_ent  = '0;
        sel_mask = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel_ent  = tbl[i];
                sel_mask = grp_mask[i];
            end
        end
        s1_d       = '0;
        s1_d.valid = lk_valid;
        if (lk_valid && (|hit_vec)) begin
            s1_d.hit = 1'b1;
            s1_d.ent = sel_ent;
            s1_d.off = vpn & ~sel_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s1_q <= '0;
        else        s1_q <= s1_d;
    end

    assign s1 = s1_q;

    AST_NO_MATCH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && hit_vec == '0) |=> (s1_q.valid && !s1_q.hit))
        else $error("miss not carried to stage one"); // R4

    AST_SLOT0_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && hit_vec[0]) |=> (s1_q.hit && s1_q.ent == $past(tbl[0])))
        else $error("lowest slot did not win"); // R8
endmodule

// File: rtl/dxl_coord.sv
module dxl_coord
    import dxl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  dxl_s1_t         s1,
    output logic            rs_valid,
    output logic            rs_hit,
    output logic            rs_miss,
    output logic [SX_W-1:0] rs_x,
    output logic [SY_W-1:0] rs_y,
    output logic [SZ_W-1:0] rs_z
);
    localparam int Y_LO = SX_W;
    localparam int Z_LO = SX_W + SY_W;

    typedef struct packed {
        logic            valid;
        logic            hit;
        logic            miss;
        logic [SX_W-1:0] x;
        logic [SY_W-1:0] y;
        logic [SZ_W-1:0] z;
    } res_t;

    res_t res_d, res_q;

    logic [RB_W-1:0]  rbits, xy_bits;
    logic [TAG_W-1:0] node_idx, xo, yo, zo;
    logic [SX_W-1:0]  sx;
    logic [SY_W-1:0]  sy;
    logic [SZ_W-1:0]  sz;

    always_comb begin
        xy_bits  = RB_W'(s1.ent.ex) + RB_W'(s1.ent.ey);
        rbits    = xy_bits + RB_W'(s1.ent.ez);
        node_idx = (s1.off >> s1.ent.ppn) & ~({TAG_W{1'b1}} << rbits);
        xo       = node_idx & ~({TAG_W{1'b1}} << s1.ent.ex);
        yo       = (node_idx >> s1.ent.ex) & ~({TAG_W{1'b1}} << s1.ent.ey);
        zo       = (node_idx >> xy_bits) & ~({TAG_W{1'b1}} << s1.ent.ez);
        sx       = s1.ent.start[Y_LO-1:0];
        sy       = s1.ent.start[Z_LO-1:Y_LO];
        sz       = s1.ent.start[START_W-1:Z_LO];

        res_d       = '0;
        res_d.valid = s1.valid;
        res_d.hit   = s1.valid && s1.hit;
        res_d.miss  = s1.valid && !s1.hit;
        if (s1.valid && s1.hit) begin
            res_d.x = sx + xo[SX_W-1:0];
            res_d.y = sy + yo[SY_W-1:0];
            res_d.z = sz + zo[SZ_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign rs_valid = res_q.valid;
    assign rs_hit   = res_q.hit;
    assign rs_miss  = res_q.miss;
    assign rs_x     = res_q.x;
    assign rs_y     = res_q.y;
    assign rs_z     = res_q.z;

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rs_miss |-> (rs_x == '0 && rs_y == '0 && rs_z == '0))
        else $error("miss with nonzero coordinates"); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |-> (!rs_hit && !rs_miss))
        else $error("flag without valid"); // R10

    AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> $onehot({rs_hit, rs_miss}))
        else $error("result neither or both hit and miss"); // R2
endmodule

// File: rtl/dest_xlate.sv
module dest_xlate
    import dxl_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [START_W-1:0] wr_start,
    input  logic [LOG_W-1:0]   wr_len,
    input  logic [LOG_W-1:0]   wr_ppn,
    input  logic [EXT_W-1:0]   wr_ext_x,
    input  logic [EXT_W-1:0]   wr_ext_y,
    input  logic [EXT_W-1:0]   wr_ext_z,
    input  logic               lk_valid,
    input  logic [VA_W-1:0]    lk_vaddr,
    output logic               rs_valid,
    output logic               rs_hit,
    output logic               rs_miss,
    output logic [SX_W-1:0]    rs_x,
    output logic [SY_W-1:0]    rs_y,
    output logic [SZ_W-1:0]    rs_z
);
    dxl_entry_t               wr_entry;
    dxl_entry_t [ENTRIES-1:0] tbl;
    logic [ENTRIES-1:0]       vld;
    dxl_s1_t                  s1;

    always_comb begin
        wr_entry.tag   = wr_tag;
        wr_entry.start = wr_start;
        wr_entry.len   = wr_len;
        wr_entry.ppn   = wr_ppn;
        wr_entry.ex    = wr_ext_x;
        wr_entry.ey    = wr_ext_y;
        wr_entry.ez    = wr_ext_z;
    end

    dxl_entry_store #(.ENTRIES(ENTRIES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_entry (wr_entry),
        .tbl      (tbl),
        .vld      (vld)
    );

    dxl_match #(.ENTRIES(ENTRIES)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_valid (lk_valid),
        .vpn      (lk_vaddr[VA_W-1:PAGE_W]),
        .tbl      (tbl),
        .vld      (vld),
        .s1       (s1)
    );

    dxl_coord u_coord (
        .clk      (clk),
        .rst_n    (rst_n),
        .s1       (s1),
        .rs_valid (rs_valid),
        .rs_hit   (rs_hit),
        .rs_miss  (rs_miss),
        .rs_x     (rs_x),
        .rs_y     (rs_y),
        .rs_z     (rs_z)
    );

    AST_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> ##1 rs_valid)
        else $error("result not two cycles after request"); // R2

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> ##1 !rs_valid)
        else $error("result without request"); // R10
endmodule

// File: tb/dest_xlate_tb.sv
module dest_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [41:0] wr_tag = '0;
    logic [15:0] wr_start = '0;
    logic [5:0]  wr_len = '0, wr_ppn = '0;
    logic [2:0]  wr_ext_x = '0, wr_ext_y = '0, wr_ext_z = '0;
    logic        lk_valid = 1'b0;
    logic [51:0] lk_vaddr = '0;
    logic        rs_valid, rs_hit, rs_miss;
    logic [4:0]  rs_x, rs_y;
    logic [5:0]  rs_z;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    dest_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tag(wr_tag), .wr_start(wr_start),
        .wr_len(wr_len), .wr_ppn(wr_ppn), .wr_ext_x(wr_ext_x), .wr_ext_y(wr_ext_y),
        .wr_ext_z(wr_ext_z), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_miss(rs_miss),
        .rs_x(rs_x), .rs_y(rs_y), .rs_z(rs_z)
    );

    // {vaddr, hit, x, y, z}; expected values worked out from R3, R5, R6
    localparam int NV = 12;
    localparam logic [68:0] VEC [NV] = '{
        {52'h000000004143A, 1'b1, 5'd4,  5'd8,  6'd10}, // R5 cyclic, idx 5
        {52'h0000000043C00, 1'b1, 5'd6,  5'd8,  6'd11}, // R5 last page of group
        {52'h0000000044000, 1'b0, 5'd0,  5'd0,  6'd0 }, // R3 one page past group
        {52'h0000000805C00, 1'b1, 5'd31, 5'd31, 6'd63}, // R5 block of 4
        {52'h0000000803800, 1'b1, 5'd31, 5'd0,  6'd63}, // R6 Y wraps alone
        {52'h0000000802000, 1'b1, 5'd30, 5'd0,  6'd63}, // R6
        {52'h000000080FC00, 1'b1, 5'd31, 5'd0,  6'd63}, // R5 modulo region
        {52'h0000000C003FF, 1'b1, 5'd1,  5'd2,  6'd3 }, // R3 single-page group
        {52'h0000000C00400, 1'b0, 5'd0,  5'd0,  6'd0 }, // R4 miss
        {52'h0000001001800, 1'b1, 5'd3,  5'd0,  6'd0 }, // R6 X wraps
        {52'h0000001001C00, 1'b1, 5'd4,  5'd0,  6'd0 }, // R6
        {52'h0000000040000, 1'b1, 5'd3,  5'd7,  6'd10}  // R8 slot 0 over slot 3
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_res(input string req, input bit eh, input logic [4:0] ex,
                           input logic [4:0] ey, input logic [5:0] ez);
        chk(rs_valid == 1'b1, req, "valid", rs_valid, 1);
        chk(rs_hit == eh, req, "hit", rs_hit, eh);
        chk(rs_miss == !eh, req, "miss", rs_miss, !eh);
        chk({rs_x, rs_y, rs_z} == {ex, ey, ez}, req, "xyz",
            {rs_x, rs_y, rs_z}, {ex, ey, ez});
    endtask

    task automatic load(input logic [41:0] tg, input logic [15:0] st, input logic [5:0] ln,
                        input logic [5:0] pp, input logic [2:0] ex, input logic [2:0] ey,
                        input logic [2:0] ez);
        @(negedge clk);
        wr_en = 1'b1; wr_tag = tg; wr_start = st; wr_len = ln; wr_ppn = pp;
        wr_ext_x = ex; wr_ext_y = ey; wr_ext_z = ez;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [51:0] va, input string req, input bit eh,
                        input logic [4:0] ex, input logic [4:0] ey, input logic [5:0] ez);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va;
        @(negedge clk);
        lk_valid = 1'b0;
        @(negedge clk);
        chk_res(req, eh, ex, ey, ez);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset, and empty table misses
        chk(!rs_valid && !rs_hit && !rs_miss, "R1", "idle flags",
            {rs_valid, rs_hit, rs_miss}, 0);
        look(52'h000000004143A, "R1", 1'b0, 5'd0, 5'd0, 6'd0);

        load(42'h100,  16'h28E3, 6'd4, 6'd0, 3'd2, 3'd1, 3'd1); // slot 0
        load(42'h2000, 16'hFFFE, 6'd6, 6'd2, 3'd1, 3'd1, 3'd0); // slot 1

        // R9: write and lookup in one cycle, then again a cycle later
        @(negedge clk);
        wr_en = 1'b1; wr_tag = 42'h3000; wr_start = 16'h0C41; wr_len = 6'd0; wr_ppn = 6'd0;
        wr_ext_x = 3'd0; wr_ext_y = 3'd0; wr_ext_z = 3'd0;
        lk_valid = 1'b1; lk_vaddr = 52'h0000000C00000;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        lk_valid = 1'b0;
        chk_res("R9 same cycle", 1'b0, 5'd0, 5'd0, 6'd0);
        @(negedge clk);
        chk_res("R9 next cycle", 1'b1, 5'd1, 5'd2, 6'd3);

        load(42'h100,  16'h0000, 6'd4, 6'd0, 3'd2, 3'd1, 3'd1); // slot 3, overlaps slot 0
        load(42'h4000, 16'h001D, 6'd3, 6'd0, 3'd3, 3'd0, 3'd0); // slot 4

        // R2: stream the table back to back, one result per cycle
        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i >= 2)
                chk_res($sformatf("R2 row %0d", i - 2), VEC[i-2][16], VEC[i-2][15:11],
                        VEC[i-2][10:6], VEC[i-2][5:0]);
            if (i < NV) begin
                lk_valid = 1'b1; lk_vaddr = VEC[i][68:17];
            end else begin
                lk_valid = 1'b0;
            end
        end

        // R10: no request, no result
        lk_vaddr = 52'h000000004143A;
        repeat (3) begin
            @(negedge clk);
            chk(!rs_valid && !rs_hit && !rs_miss, "R10", "idle flags",
                {rs_valid, rs_hit, rs_miss}, 0);
        end

        // R7: fill slots 5..7, ninth write lands in slot 0
        load(42'h7000, 16'h0000, 6'd0, 6'd0, 3'd0, 3'd0, 3'd0);
        load(42'h7100, 16'h0000, 6'd0, 6'd0, 3'd0, 3'd0, 3'd0);
        load(42'h7200, 16'h0000, 6'd0, 6'd0, 3'd0, 3'd0, 3'd0);
        look(52'h0000000040000, "R7 slot 0 still old", 1'b1, 5'd3, 5'd7, 6'd10);
        load(42'h5000, 16'h1CC5, 6'd0, 6'd0, 3'd0, 3'd0, 3'd0);
        look(52'h0000001400000, "R7 new entry", 1'b1, 5'd5, 5'd6, 6'd7);
        look(52'h000000004143A, "R7 slot 3 now answers", 1'b1, 5'd1, 5'd1, 6'd0);
        look(52'h0000001C80000, "R7 slot 7 kept", 1'b1, 5'd0, 5'd0, 6'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule